// File: doc/BRIEF.md
# Interrupt Status and Vector Unit

This block collects the event strobes of a serial-bus master engine and presents them to a host processor. Each event sets a sticky flag in a status word. The host clears a flag by writing a one to its position. A separate mask word chooses which flags drive the single interrupt line. One status bit is not sticky: it shows the live bus-busy level instead.

For software that expects an older programming model, a read-only code register is also provided. A read of it returns the number of the highest-priority pending event among the five core events. The same read clears the reported flag, so repeated reads step through the pending events one by one.

The register port is a simple one-cycle strobe interface. Read data is registered and valid on the cycle after the read strobe. The interrupt output is also registered, and it changes on the same edge as the flags and mask that produce it.

Top module: `ivu_irq_vector`

## Requirements
- R1: After a synchronous reset, and with the bus-busy input low, the status word, the mask word, the read data and the interrupt output are all zero.
- R2: A one on an event strobe sets the matching sticky status bit on the next clock edge, and the bit stays set until it is cleared. The sticky bits are 0 arbitration lost, 1 no-acknowledge, 2 access ready, 3 receive ready, 4 transmit ready, 8 address zero, 9 addressed as slave, 10 transmit underflow, 11 receive overrun, 13 receive drain and 14 transmit drain.
- R3: A write to the status word (address 0) clears every sticky bit written as one and leaves every bit written as zero unchanged.
- R4: If an event strobe and a write-one clear of the same bit fall in the same cycle, the bit stays set.
- R5: Status bit 12 shows the bus-busy input as sampled at the previous clock edge, and writing a one to it has no effect.
- R6: Status bits 5, 6, 7 and 15 always read zero, and strobes on those positions are ignored.
- R7: The mask word (address 1) is writable only at bits 0 to 4, 13 and 14, and its other bits read zero.
- R8: The interrupt output is high exactly when some status bit and its mask bit are both set, and it follows from the same clock edge that updates them.
- R9: A read of the code register (address 2) returns 0 when none of bits 0 to 4 is pending. Otherwise it returns the lowest pending bit position plus one (1 arbitration lost, 2 no-acknowledge, 3 access ready, 4 receive ready, 5 transmit ready), and the mask word is not taken into account.
- R10: A code-register read clears only the reported status bit.
- R11: Read data appears on the cycle after the read strobe, address 3 reads zero, and read data holds its value when no read is made.
- R12: An event strobe that arrives in the same cycle as the code read reporting that event keeps the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_i | input | 16 | Event strobes, one per status position |
| bus_busy_i | input | 1 | Live bus-busy level |
| rd_en_i | input | 1 | Register read strobe |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register select: 0 status, 1 mask, 2 code, 3 reserved |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data |
| irq_o | output | 1 | Registered interrupt request |

## Verification
A new event can collide with either of the two clearing paths in the same cycle. One path is the write-one clear of the status word and the other is the clear-on-read of the code register. The bench provokes each collision by driving the strobe and the clearing access on one clock edge. It then reads the status word back, and the event must have won. It also confirms that the colliding code read still reported the event it found pending.

// File: rtl/ivu_pkg.sv
package ivu_pkg;

  // Register select codes seen on the host port
  typedef enum logic [1:0] {
    REG_FLAGS = 2'd0,
    REG_MASK  = 2'd1,
    REG_CODE  = 2'd2,
    REG_NONE  = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/ivu_flag_bank.sv
module ivu_flag_bank #(
  parameter int unsigned     DW       = 16,
  parameter logic [DW-1:0]   STICKY   = 16'h6F1F,
  parameter int unsigned     LIVE_BIT = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] ev_i,
  input  logic          live_i,
  input  logic [DW-1:0] clr_i,
  output logic [DW-1:0] flags_d,
  output logic [DW-1:0] flags_q
);

  localparam logic [DW-1:0] LIVE_MASK = DW'(1) << LIVE_BIT;

  for (genvar i = 0; i < DW; i++) begin : g_bit
    if (i == LIVE_BIT) begin : g_live
      assign flags_d[i] = live_i;
    end else if (STICKY[i]) begin : g_sticky
      // a new event outranks any clear of the same bit
      assign flags_d[i] = ev_i[i] | (flags_q[i] & ~clr_i[i]);
    end else begin : g_zero
      assign flags_d[i] = 1'b0;
    end
  end

  // live bit keeps sampling during reset so it never lags the input
  always_ff @(posedge clk) begin
    if (rst) flags_q <= flags_d & LIVE_MASK;
    else     flags_q <= flags_d;
  end

  // R2 / R4: a strobed sticky bit is set on the next edge
  a_r2_event_sets: assert property (@(posedge clk) disable iff (rst)
    |(ev_i & STICKY) |=> ((flags_q & $past(ev_i & STICKY)) == $past(ev_i & STICKY)));

  // R3: a set sticky bit without a clear stays set
  a_r3_hold_unless_cleared: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((($past(flags_q) & ~$past(clr_i) & STICKY) & ~flags_q) == '0));

  // R5: live bit mirrors the input one edge later
  a_r5_live_follow: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (flags_q[LIVE_BIT] == $past(live_i)));

endmodule

// File: rtl/ivu_vec_enc.sv
module ivu_vec_enc #(
  parameter int unsigned NEV = 5,
  parameter int unsigned CW  = $clog2(NEV + 1)
) (
  input  logic [NEV-1:0] pend_i,
  output logic [CW-1:0]  code_o,
  output logic [NEV-1:0] hit_o
);

  // lowest position wins: scan from the top so the last match is kept
  always_comb begin
    code_o = '0;
    hit_o  = '0;
    for (int i = NEV - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        code_o    = CW'(i + 1);
        hit_o     = '0;
        hit_o[i]  = 1'b1;
      end
    end
  end

endmodule

// File: rtl/ivu_reg_port.sv
module ivu_reg_port
  import ivu_pkg::*;
#(
  parameter int unsigned   DW      = 16,
  parameter logic [DW-1:0] EN_MASK = 16'h601F,
  parameter int unsigned   CW      = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en_i,
  input  logic          wr_en_i,
  input  logic [1:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] flags_q_i,
  input  logic [CW-1:0] code_i,
  output logic [DW-1:0] mask_d,
  output logic [DW-1:0] mask_q,
  output logic [DW-1:0] w1c_o,
  output logic          code_rd_o,
  output logic [DW-1:0] rdata_o
);

  reg_sel_e sel;
  logic [DW-1:0] rd_mux;

  assign sel       = reg_sel_e'(addr_i);
  assign mask_d    = (wr_en_i && sel == REG_MASK) ? (wdata_i & EN_MASK) : mask_q;
  assign w1c_o     = (wr_en_i && sel == REG_FLAGS) ? wdata_i : '0;
  assign code_rd_o = rd_en_i && (sel == REG_CODE);

  always_comb begin
    unique case (sel)
      REG_FLAGS: rd_mux = flags_q_i;
      REG_MASK:  rd_mux = mask_q;
      REG_CODE:  rd_mux = DW'(code_i);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '0;
      rdata_o <= '0;
    end else begin
      mask_q <= mask_d;
      if (rd_en_i) rdata_o <= rd_mux;
    end
  end

  // R11: a mask read returns the mask held in the read cycle
  a_r11_mask_readback: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && addr_i == 2'd1) |=> (rdata_o == $past(mask_q)));

  // R11: read data holds when no read is made
  a_r11_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    (!rd_en_i && !rst) |=> $stable(rdata_o));

endmodule

// File: rtl/ivu_irq_vector.sv
module ivu_irq_vector #(
  parameter int unsigned   DW       = 16,
  parameter logic [DW-1:0] STICKY   = 16'h6F1F,
  parameter logic [DW-1:0] EN_MASK  = 16'h601F,
  parameter int unsigned   BUSY_BIT = 12,
  parameter int unsigned   NVEC     = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] ev_i,
  input  logic          bus_busy_i,
  input  logic          rd_en_i,
  input  logic          wr_en_i,
  input  logic [1:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o
);

  localparam int unsigned CW = $clog2(NVEC + 1);

  logic [DW-1:0]   flags_d, flags_q;
  logic [DW-1:0]   mask_d, mask_q;
  logic [DW-1:0]   w1c, vec_clr, clr;
  logic [CW-1:0]   code;
  logic [NVEC-1:0] hit;
  logic            code_rd;

  assign vec_clr = code_rd ? DW'(hit) : '0;
  assign clr     = w1c | vec_clr;

  ivu_flag_bank #(.DW(DW), .STICKY(STICKY), .LIVE_BIT(BUSY_BIT)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .ev_i    (ev_i),
    .live_i  (bus_busy_i),
    .clr_i   (clr),
    .flags_d (flags_d),
    .flags_q (flags_q)
  );

  ivu_vec_enc #(.NEV(NVEC), .CW(CW)) u_enc (
    .pend_i (flags_q[NVEC-1:0]),
    .code_o (code),
    .hit_o  (hit)
  );

  ivu_reg_port #(.DW(DW), .EN_MASK(EN_MASK), .CW(CW)) u_port (
    .clk       (clk),
    .rst       (rst),
    .rd_en_i   (rd_en_i),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .flags_q_i (flags_q),
    .code_i    (code),
    .mask_d    (mask_d),
    .mask_q    (mask_q),
    .w1c_o     (w1c),
    .code_rd_o (code_rd),
    .rdata_o   (rdata_o)
  );

  // interrupt registered from next-state so it lines up with the flags
  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |(flags_d & mask_d);
  end

  // R8: interrupt matches the held flags and mask
  a_r8_irq_match: assert property (@(posedge clk) disable iff (rst)
    irq_o == |(flags_q & mask_q));

  // R10: the code read selects at most one flag to clear
  a_r10_single_clear: assert property (@(posedge clk) disable iff (rst)
    $onehot0(vec_clr));

  // R10 / R12: the reported flag is gone unless an event refilled it
  a_r10_reported_cleared: assert property (@(posedge clk) disable iff (rst)
    code_rd |=> ((flags_q & $past(vec_clr) & ~$past(ev_i)) == '0));

  // R9: no pending core event reads as code zero
  a_r9_idle_code: assert property (@(posedge clk) disable iff (rst)
    (code_rd && flags_q[NVEC-1:0] == '0) |=> (rdata_o == '0));

endmodule

// File: tb/sim_ivu_irq_vector.sv
`timescale 1ns/1ps
module sim_ivu_irq_vector;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] ev = '0;
  logic        busy = 1'b0;
  logic        rd = 1'b0;
  logic        wr = 1'b0;
  logic [1:0]  adr = '0;
  logic [15:0] wd = '0;
  logic [15:0] rdata;
  logic        irq;

  int n_run  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  ivu_irq_vector u0 (
    .clk(clk), .rst(rst), .ev_i(ev), .bus_busy_i(busy),
    .rd_en_i(rd), .wr_en_i(wr), .addr_i(adr), .wdata_i(wd),
    .rdata_o(rdata), .irq_o(irq)
  );

  typedef struct packed {
    logic [1:0]  op;    // 0 idle, 1 write, 2 read
    logic [1:0]  adr;
    logic [15:0] wd;
    logic [15:0] ev;
    logic        busy;
    logic [15:0] exp_rd;
    logic        exp_irq;
    logic [3:0]  req;
  } step_t;

  localparam int NSTEP = 31;
  localparam step_t TBL [NSTEP] = '{
    '{2'd1, 2'd1, 16'hFFFF, 16'h0000, 1'b0, 16'h0000, 1'b0, 4'd7 },  // R7 mask write
    '{2'd2, 2'd1, 16'h0000, 16'h0000, 1'b0, 16'h601F, 1'b0, 4'd7 },  // R7 mask read
    '{2'd0, 2'd0, 16'h0000, 16'h0001, 1'b0, 16'h0000, 1'b1, 4'd2 },  // R2 event, R8 irq
    '{2'd2, 2'd0, 16'h0000, 16'h0000, 1'b0, 16'h0001, 1'b1, 4'd2 },
    '{2'd1, 2'd0, 16'h0000, 16'h0000, 1'b0, 16'h0000, 1'b1, 4'd3 },  // R3 zero write
    '{2'd1, 2'd0, 16'h0001, 16'h0000, 1'b0, 16'h0000, 1'b0, 4'd3 },  // R3 one clears
    '{2'd0, 2'd0, 16'h0000, 16'h0F00, 1'b0, 16'h0000, 1'b0, 4'd8 },  // R8 unmasked
    '{2'd2, 2'd0, 16'h0000, 16'h0000, 1'b0, 16'h0F00, 1'b0, 4'd2 },
    '{2'd0, 2'd0, 16'h0000, 16'h80E0, 1'b0, 16'h0000, 1'b0, 4'd6 },  // R6 unused
    '{2'd2, 2'd0, 16'h0000, 16'h0000, 1'b0, 16'h0F00, 1'b0, 4'd6 },
    '{2'd1, 2'd0, 16'h0F00, 16'h0000, 1'b0, 16'h0000, 1'b0, 4'd3 },
    '{2'd0, 2'd0, 16'h0000, 16'h0000, 1'b1, 16'h0000, 1'b0, 4'd5 },  // R5 busy
    '{2'd1, 2'd0, 16'h1000, 16'h0000, 1'b1, 16'h0000, 1'b0, 4'd5 },
    '{2'd2, 2'd0, 16'h0000, 16'h0000, 1'b1, 16'h1000, 1'b0, 4'd5 },
    '{2'd0, 2'd0, 16'h0000, 16'h0000, 1'b0, 16'h0000, 1'b0, 4'd5 },
    '{2'd2, 2'd0, 16'h0000, 16'h0000, 1'b0, 16'h0000, 1'b0, 4'd5 },
    '{2'd0, 2'd0, 16'h0000, 16'h001C, 1'b0, 16'h0000, 1'b1, 4'd2 },
    '{2'd2, 2'd2, 16'h0000, 16'h0000, 1'b0, 16'h0003, 1'b1, 4'd9 },  // R9 lowest
    '{2'd2, 2'd2, 16'h0000, 16'h0000, 1'b0, 16'h0004, 1'b1, 4'd9 },
    '{2'd2, 2'd0, 16'h0000, 16'h0000, 1'b0, 16'h0010, 1'b1, 4'd10},  // R10
    '{2'd2, 2'd2, 16'h0000, 16'h0000, 1'b0, 16'h0005, 1'b0, 4'd9 },
    '{2'd2, 2'd2, 16'h0000, 16'h0000, 1'b0, 16'h0000, 1'b0, 4'd9 },
    '{2'd1, 2'd0, 16'h0002, 16'h0002, 1'b0, 16'h0000, 1'b1, 4'd4 },  // R4 collision
    '{2'd2, 2'd0, 16'h0000, 16'h0000, 1'b0, 16'h0002, 1'b1, 4'd4 },
    '{2'd1, 2'd1, 16'h0000, 16'h0000, 1'b0, 16'h0000, 1'b0, 4'd8 },
    '{2'd2, 2'd2, 16'h0000, 16'h0000, 1'b0, 16'h0002, 1'b0, 4'd9 },  // mask ignored
    '{2'd2, 2'd0, 16'h0000, 16'h0000, 1'b0, 16'h0000, 1'b0, 4'd10},
    '{2'd0, 2'd0, 16'h0000, 16'h6000, 1'b0, 16'h0000, 1'b0, 4'd8 },
    '{2'd1, 2'd1, 16'h4000, 16'h0000, 1'b0, 16'h0000, 1'b1, 4'd8 },
    '{2'd2, 2'd3, 16'h0000, 16'h0000, 1'b0, 16'h0000, 1'b1, 4'd11},  // R11 reserved
    '{2'd1, 2'd0, 16'h6000, 16'h0000, 1'b0, 16'h0000, 1'b0, 4'd3 }
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a falling edge: drive for one cycle, return at the next falling edge
  task automatic cyc(input logic [1:0] op, input logic [1:0] a, input logic [15:0] d,
                     input logic [15:0] e, input logic b);
    wr = (op == 2'd1); rd = (op == 2'd2); adr = a; wd = d; ev = e; busy = b;
    @(negedge clk);
    wr = 1'b0; rd = 1'b0; ev = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    step_t s;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 rdata", rdata, 16'h0);
    chk("R1 irq", {15'h0, irq}, 16'h0);
    cyc(2'd2, 2'd0, 16'h0, 16'h0, 1'b0);
    chk("R1 status", rdata, 16'h0);
    cyc(2'd2, 2'd1, 16'h0, 16'h0, 1'b0);
    chk("R1 mask", rdata, 16'h0);

    for (int k = 0; k < NSTEP; k++) begin
      s = TBL[k];
      cyc(s.op, s.adr, s.wd, s.ev, s.busy);
      if (s.op == 2'd2) chk($sformatf("R%0d step %0d rdata", s.req, k), rdata, s.exp_rd);
      chk($sformatf("R%0d step %0d irq", s.req, k), {15'h0, irq}, {15'h0, s.exp_irq});
    end

    // R12: event arrives with the code read that reports it
    cyc(2'd0, 2'd0, 16'h0, 16'h0001, 1'b0);
    cyc(2'd2, 2'd2, 16'h0, 16'h0001, 1'b0);
    chk("R12 code", rdata, 16'h0001);
    cyc(2'd2, 2'd0, 16'h0, 16'h0, 1'b0);
    chk("R12 status kept", rdata, 16'h0001);

    // R9: both ends of the priority range pending, lowest first
    cyc(2'd0, 2'd0, 16'h0, 16'h0010, 1'b0);
    cyc(2'd2, 2'd2, 16'h0, 16'h0, 1'b0);
    chk("R9 first", rdata, 16'h0001);
    cyc(2'd2, 2'd2, 16'h0, 16'h0, 1'b0);
    chk("R9 second", rdata, 16'h0005);

    // R11: read data holds through idle cycles
    cyc(2'd0, 2'd0, 16'h0, 16'h0, 1'b0);
    cyc(2'd0, 2'd0, 16'h0, 16'h0, 1'b0);
    chk("R11 hold", rdata, 16'h0005);

    // R1: reset in mid-run clears flags, mask and irq
    cyc(2'd1, 2'd1, 16'h0001, 16'h0, 1'b0);
    cyc(2'd0, 2'd0, 16'h0, 16'h0001, 1'b0);
    chk("R8 irq before reset", {15'h0, irq}, 16'h1);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk("R1 irq after reset", {15'h0, irq}, 16'h0);
    chk("R1 rdata after reset", rdata, 16'h0);
    cyc(2'd2, 2'd0, 16'h0, 16'h0, 1'b0);
    chk("R1 status after reset", rdata, 16'h0);
    cyc(2'd2, 2'd1, 16'h0, 16'h0, 1'b0);
    chk("R1 mask after reset", rdata, 16'h0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule